// File: doc/BRIEF.md
# Indirect-Access Lookup Table Window

This block puts a small register window in front of an on-chip table of switch lookup entries. Each entry is 68 bits wide by default. Software never addresses an entry directly. It writes an index into a table-control register, and that write either copies the selected entry into three 32-bit staging words or stores the staging words into the entry. The 68-bit entry is split across the staging words in reversed order. Entry bits 31:0 sit in the highest-addressed word, bits 63:32 in the middle word, and bits 67:64 in the lowest-addressed word.

The window also has two more registers. A read-only identification register reports the major and minor revision. A global control register holds the engine-enable bit and two self-clearing request bits. The first request starts a table clear, which walks every entry and writes one entry per cycle. The second request sends a one-cycle age-out strobe to the aging logic next to the block.

The sequencing is done by a three-state engine:

- **IDLE** is the resting state.
- **CLEAR** walks the table. It holds the busy flag until the last index has been written.
- **AGE** lasts exactly one cycle and drives the strobe.

The transitions are:

- IDLE→CLEAR and AGE→CLEAR on a clear request.
- IDLE→AGE and AGE→AGE on an age request that has no clear request with it.
- AGE→IDLE otherwise.
- CLEAR→CLEAR while the walk index is below the last entry.
- CLEAR→IDLE once the last entry has been written.

Top module: `tw_window`

## Requirements
- R1: After reset, all of the following read 0: the control register, the table-control register and all three staging words. The outputs `engine_en` and `age_strobe` are 0, and every table entry is zero, so its type field (entry bits 61:60, read at word 0x38 bits 29:28) is 0 (free).
- R2: Address 0x00 always reads {16'h0, VER_MAJOR, VER_MINOR} (defaults 8'h01 and 8'h03, so 0x0000_0103). Writes to it have no effect.
- R3: Writing 0x20 with bit 31 = 0 and index i < DEPTH in bits IDX_W-1:0 loads entry i into the staging words. From the next cycle, 0x3C reads entry bits 31:0, 0x38 reads bits 63:32, and 0x34 reads bits 67:64 zero-extended.
- R4: Writing 0x20 with bit 31 = 1 stores {0x34[3:0], 0x38, 0x3C} into entry i. The staging words keep their contents.
- R5: An index ≥ DEPTH is handled as follows. A commit to it changes no entry, including entry index mod DEPTH. A load from it fills all three staging words with zero.
- R6: Every write to control 0x08 stores bit 31 as the engine-enable bit. From the next cycle it is seen on `engine_en` and read back at 0x08 bit 31.
- R7: A control write with bit 30 set while the engine is idle starts a clear. Starting the next cycle, control bits 30 and 28 read 1 for exactly DEPTH cycles and then return to 0. Afterwards every entry reads as zero (type free).
- R8: A control write with bit 29 set and bit 30 clear, while no clear is running, drives `age_strobe` high for exactly the next cycle. Control bit 29 reads 1 only in that cycle.
- R9: While a clear is running, table-control writes are ignored. No load happens, no commit happens, and the index read at 0x20 does not change.
- R10: The clear request takes precedence over the age request. An age request written together with a clear request, or while a clear is running, produces no strobe.
- R11: 0x20 reads back the last accepted index with bit 31 = 0. An address that is unmapped or has a nonzero value in bits 1:0 reads 0, and writes to such an address change nothing.
- R12: Word 0x34 keeps only its low ENTRY_W-64 bits (4 by default). Its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per register write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| engine_en | output | 1 | Engine-enable bit from the control register |
| age_strobe | output | 1 | One-cycle age-out pulse for the aging logic |

## Verification
Register reads are combinational, so a value is due in the same cycle as its address. All other results are due at the first rising edge after the write:

- the staging words after a load,
- the enable bit,
- the age strobe, which is high for that cycle only,
- the first cycle of the busy flag.

The busy flag then stays high for DEPTH cycles. The bench drives inputs on the falling edge and samples one nanosecond later. A result is read at the falling edge that follows the write's rising edge. During a clear the busy flag and the strobe are sampled at every falling edge, so both the exact busy length and the absence of a strobe are counted cycle by cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_VER,
        REG_CTRL,
        REG_TBL,
        REG_E0,
        REG_E1,
        REG_E2
    } reg_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_AGE
    } eng_state_t;

    // word indices (byte address / 4) of the mapped registers
    localparam int WORD_VER  = 0;
    localparam int WORD_CTRL = 2;
    localparam int WORD_TBL  = 8;
    localparam int WORD_E0   = 13;
    localparam int WORD_E1   = 14;
    localparam int WORD_E2   = 15;

    // control register bits
    localparam int BIT_EN     = 31;
    localparam int BIT_CLR    = 30;
    localparam int BIT_AGE    = 29;
    localparam int BIT_BUSY   = 28;
    // table-control register commit bit
    localparam int BIT_COMMIT = 31;

endpackage

// File: rtl/tw_decode.sv
module tw_decode
    import tw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0] word;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        sel = REG_NONE;
        if (addr[1:0] == 2'b00) begin
            if (word == WA_W'(WORD_VER))       sel = REG_VER;
            else if (word == WA_W'(WORD_CTRL)) sel = REG_CTRL;
            else if (word == WA_W'(WORD_TBL))  sel = REG_TBL;
            else if (word == WA_W'(WORD_E0))   sel = REG_E0;
            else if (word == WA_W'(WORD_E1))   sel = REG_E1;
            else if (word == WA_W'(WORD_E2))   sel = REG_E2;
        end
    end

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_wr,
    input  logic                     req_en,
    input  logic                     req_clr,
    input  logic                     req_age,
    output logic                     engine_en,
    output logic                     busy,
    output logic                     age_strobe,
    output logic                     clr_we,
    output logic [$clog2(DEPTH)-1:0] clr_idx
);

    localparam int             CLR_W = $clog2(DEPTH);
    localparam logic [CLR_W-1:0] LAST = CLR_W'(DEPTH - 1);

    eng_state_t       state_q, state_d;
    logic [CLR_W-1:0] walk_q;
    logic             en_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_AGE: begin
                if (ctrl_wr && req_clr)      state_d = ST_CLEAR;
                else if (ctrl_wr && req_age) state_d = ST_AGE;
                else                         state_d = ST_IDLE;
            end
            ST_CLEAR: begin
                if (walk_q == LAST)          state_d = ST_IDLE;
            end
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state register, walk index and enable bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            walk_q  <= '0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR && walk_q != LAST)
                walk_q <= walk_q + 1'b1;
            else
                walk_q <= '0;
            if (ctrl_wr)
                en_q <= req_en;
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy       = (state_q == ST_CLEAR);
        clr_we     = (state_q == ST_CLEAR);
        age_strobe = (state_q == ST_AGE);
        clr_idx    = walk_q;
        engine_en  = en_q;
    end

endmodule

// File: rtl/tw_entry_regs.sv
module tw_entry_regs #(
    parameter int ENTRY_W = 68,
    parameter int IDX_W   = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_e0,
    input  logic                  wr_e1,
    input  logic                  wr_e2,
    input  logic [31:0]           wdata,
    input  logic                  load,
    input  logic [ENTRY_W-1:0]    load_data,
    input  logic                  idx_upd,
    input  logic [IDX_W-1:0]      idx_in,
    output logic [ENTRY_W-65:0]   hi_q,
    output logic [31:0]           mid_q,
    output logic [31:0]           lo_q,
    output logic [IDX_W-1:0]      idx_q,
    output logic [ENTRY_W-1:0]    entry_out
);

    localparam int HI_W = ENTRY_W - 64;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            mid_q <= '0;
            lo_q  <= '0;
            idx_q <= '0;
        end else begin
            if (load) begin
                hi_q  <= load_data[ENTRY_W-1:64];
                mid_q <= load_data[63:32];
                lo_q  <= load_data[31:0];
            end else begin
                if (wr_e0) hi_q  <= wdata[HI_W-1:0];
                if (wr_e1) mid_q <= wdata;
                if (wr_e2) lo_q  <= wdata;
            end
            if (idx_upd)
                idx_q <= idx_in;
        end
    end

    assign entry_out = {hi_q, mid_q, lo_q};

endmodule

// File: rtl/tw_store.sv
module tw_store #(
    parameter int ENTRY_W = 68,
    parameter int DEPTH   = 64,
    parameter int IDX_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_we,
    input  logic [$clog2(DEPTH)-1:0] clr_idx,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [ENTRY_W-1:0]       wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [ENTRY_W-1:0]       rd_data
);

    localparam int CLR_W = $clog2(DEPTH);

    logic [ENTRY_W-1:0] ent_q [DEPTH];
    logic [DEPTH-1:0]   hit;

    // per-entry write select; an index at or beyond DEPTH matches none
    for (genvar e = 0; e < DEPTH; e++) begin : g_hit
        assign hit[e] = (clr_we && clr_idx == CLR_W'(e)) ||
                        (wr_en  && wr_idx  == IDX_W'(e));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++)
                ent_q[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++)
                if (hit[e])
                    ent_q[e] <= clr_we ? '0 : wr_data;
        end
    end

    // read port; an out-of-range index returns zero
    always_comb begin
        rd_data = '0;
        for (int e = 0; e < DEPTH; e++)
            if (rd_idx == IDX_W'(e))
                rd_data = ent_q[e];
    end

endmodule

// File: rtl/tw_window.sv
module tw_window
    import tw_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         ENTRY_W   = 68,
    parameter int         DEPTH     = 64,
    parameter int         IDX_W     = 10,
    parameter logic [7:0] VER_MAJOR = 8'h01,
    parameter logic [7:0] VER_MINOR = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              engine_en,
    output logic              age_strobe
);

    localparam int CLR_W = $clog2(DEPTH);
    localparam int HI_W  = ENTRY_W - 64;

    reg_sel_t           sel;
    logic               ctrl_wr;
    logic               tbl_wr;
    logic               tbl_load;
    logic               tbl_commit;
    logic               busy;
    logic               clr_we;
    logic [CLR_W-1:0]   clr_idx;
    logic [IDX_W-1:0]   req_idx;
    logic [ENTRY_W-1:0] rd_entry;
    logic [ENTRY_W-1:0] stage_entry;
    logic [HI_W-1:0]    hi_q;
    logic [31:0]        mid_q;
    logic [31:0]        lo_q;
    logic [IDX_W-1:0]   idx_q;
    logic [31:0]        ctrl_rd;

    tw_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign ctrl_wr    = bus_wr && (sel == REG_CTRL);
    assign tbl_wr     = bus_wr && (sel == REG_TBL) && !busy;
    assign tbl_load   = tbl_wr && !bus_wdata[BIT_COMMIT];
    assign tbl_commit = tbl_wr &&  bus_wdata[BIT_COMMIT];
    assign req_idx    = bus_wdata[IDX_W-1:0];

    tw_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .req_en     (bus_wdata[BIT_EN]),
        .req_clr    (bus_wdata[BIT_CLR]),
        .req_age    (bus_wdata[BIT_AGE]),
        .engine_en  (engine_en),
        .busy       (busy),
        .age_strobe (age_strobe),
        .clr_we     (clr_we),
        .clr_idx    (clr_idx)
    );

    tw_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_we  (clr_we),
        .clr_idx (clr_idx),
        .wr_en   (tbl_commit),
        .wr_idx  (req_idx),
        .wr_data (stage_entry),
        .rd_idx  (req_idx),
        .rd_data (rd_entry)
    );

    tw_entry_regs #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_e0     (bus_wr && (sel == REG_E0)),
        .wr_e1     (bus_wr && (sel == REG_E1)),
        .wr_e2     (bus_wr && (sel == REG_E2)),
        .wdata     (bus_wdata),
        .load      (tbl_load),
        .load_data (rd_entry),
        .idx_upd   (tbl_wr),
        .idx_in    (req_idx),
        .hi_q      (hi_q),
        .mid_q     (mid_q),
        .lo_q      (lo_q),
        .idx_q     (idx_q),
        .entry_out (stage_entry)
    );

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[BIT_EN]   = engine_en;
        ctrl_rd[BIT_CLR]  = busy;
        ctrl_rd[BIT_AGE]  = age_strobe;
        ctrl_rd[BIT_BUSY] = busy;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_VER:  bus_rdata = {16'h0000, VER_MAJOR, VER_MINOR};
            REG_CTRL: bus_rdata = ctrl_rd;
            REG_TBL:  bus_rdata = 32'(idx_q);
            REG_E0:   bus_rdata = 32'(hi_q);
            REG_E1:   bus_rdata = mid_q;
            REG_E2:   bus_rdata = lo_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tw_window_chk.sv
module tw_window_chk #(
    parameter int DEPTH = 64
) (
    input logic clk,
    input logic rst_n,
    input logic ctrl_wr,
    input logic req_en,
    input logic req_clr,
    input logic req_age,
    input logic engine_en,
    input logic age_strobe,
    input logic busy
);

    int unsigned run_q;

    // length of the current busy run, counted in cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 0;
        else        run_q <= busy ? run_q + 1 : 0;
    end

    a_r6_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> engine_en == $past(req_en));

    a_r8_strobe_due: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && req_age && !req_clr && !busy) |=> age_strobe);

    a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        age_strobe |-> $past(ctrl_wr && req_age && !req_clr && !busy));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && req_clr && !busy) |=> (busy && !age_strobe));

    a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < DEPTH);

    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == DEPTH);

endmodule

bind tw_window tw_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .req_en     (bus_wdata[tw_pkg::BIT_EN]),
    .req_clr    (bus_wdata[tw_pkg::BIT_CLR]),
    .req_age    (bus_wdata[tw_pkg::BIT_AGE]),
    .engine_en  (engine_en),
    .age_strobe (age_strobe),
    .busy       (busy)
);

// File: tb/tw_window_test.sv
`timescale 1ns/1ps
module tw_window_test;

    localparam logic [7:0] A_VER  = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_TBL  = 8'h20;
    localparam logic [7:0] A_E0   = 8'h34;
    localparam logic [7:0] A_E1   = 8'h38;
    localparam logic [7:0] A_E2   = 8'h3C;
    localparam int         DEPTH  = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        engine_en;
    logic        age_strobe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tw_window uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .engine_en  (engine_en),
        .age_strobe (age_strobe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        #1;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        peek(a, d);
        check(tag, d, exp);
    endtask

    task automatic check_words(input string tag, input logic [31:0] e0,
                               input logic [31:0] e1, input logic [31:0] e2);
        check_reg({tag, " word0"}, A_E0, e0);
        check_reg({tag, " word1"}, A_E1, e1);
        check_reg({tag, " word2"}, A_E2, e2);
    endtask

    task automatic wait_idle(output int cycles);
        logic [31:0] d;
        cycles = 0;
        peek(A_CTRL, d);
        while (d[28] && cycles < 4 * DEPTH) begin
            cycles++;
            @(negedge clk);
            #1;
            peek(A_CTRL, d);
        end
    endtask

    task automatic t_reset;
        check_reg("R1 control after reset", A_CTRL, 32'h0);
        check_reg("R1 table index after reset", A_TBL, 32'h0);
        check("R1 engine_en after reset", {31'b0, engine_en}, 32'h0);
        check("R1 age_strobe after reset", {31'b0, age_strobe}, 32'h0);
        check_words("R1 staging after reset", 32'h0, 32'h0, 32'h0);
        bus_write(A_TBL, 32'h0000_0000);
        check_words("R1 entry 0 free after reset", 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_version;
        check_reg("R2 version", A_VER, 32'h0000_0103);
        bus_write(A_VER, 32'hFFFF_FFFF);
        check_reg("R2 version after write", A_VER, 32'h0000_0103);
        check_reg("R11 unmapped 0x04", 8'h04, 32'h0);
        check_reg("R11 unmapped 0x30", 8'h30, 32'h0);
        check_reg("R11 misaligned 0x35", 8'h35, 32'h0);
    endtask

    task automatic t_store;
        bus_write(A_E0, 32'hFFFF_FFF7);
        check_reg("R12 word0 width", A_E0, 32'h0000_0007);
        bus_write(A_E1, 32'h3123_4567);
        bus_write(A_E2, 32'hA5A5_0001);
        bus_write(A_TBL, 32'h8000_0007);
        check_words("R4 staging kept after commit", 32'h7, 32'h3123_4567, 32'hA5A5_0001);
        check_reg("R11 index readback commit 7", A_TBL, 32'h0000_0007);
        bus_write(A_E0, 32'h0000_0002);
        bus_write(A_E1, 32'h1000_00AA);
        bus_write(A_E2, 32'h0000_BEEF);
        bus_write(A_TBL, 32'h8000_003F);
        bus_write(A_TBL, 32'h0000_0007);
        check_words("R3 load entry 7", 32'h7, 32'h3123_4567, 32'hA5A5_0001);
        bus_write(A_TBL, 32'h0000_003F);
        check_words("R3 load entry 63", 32'h2, 32'h1000_00AA, 32'h0000_BEEF);
        bus_write(A_TBL, 32'h0000_0008);
        check_words("R3 load untouched entry 8", 32'h0, 32'h0, 32'h0);
        bus_write(A_TBL, 32'h0000_003F);
        bus_write(8'h35, 32'h0000_DEAD);
        check_words("R11 misaligned write ignored", 32'h2, 32'h1000_00AA, 32'h0000_BEEF);
    endtask

    task automatic t_range;
        bus_write(A_E2, 32'h1111_2222);
        bus_write(A_TBL, 32'h8000_0040);
        bus_write(A_TBL, 32'h0000_0000);
        check_words("R5 commit 64 did not alias entry 0", 32'h0, 32'h0, 32'h0);
        bus_write(A_TBL, 32'h0000_003F);
        check_words("R5 entry 63 intact", 32'h2, 32'h1000_00AA, 32'h0000_BEEF);
        bus_write(A_TBL, 32'h0000_0040);
        check_words("R5 load index 64", 32'h0, 32'h0, 32'h0);
        bus_write(A_TBL, 32'h0000_003F);
        bus_write(A_TBL, 32'h0000_03FF);
        check_words("R5 load index 1023", 32'h0, 32'h0, 32'h0);
        check_reg("R11 index readback 1023", A_TBL, 32'h0000_03FF);
    endtask

    task automatic t_enable;
        bus_write(A_CTRL, 32'h8000_0000);
        check("R6 engine_en set", {31'b0, engine_en}, 32'h1);
        check_reg("R6 control readback set", A_CTRL, 32'h8000_0000);
        bus_write(A_CTRL, 32'h0000_0000);
        check("R6 engine_en cleared", {31'b0, engine_en}, 32'h0);
        check_reg("R6 control readback cleared", A_CTRL, 32'h0);
    endtask

    task automatic t_age;
        bus_write(A_CTRL, 32'h2000_0000);
        check("R8 strobe in first cycle", {31'b0, age_strobe}, 32'h1);
        check_reg("R8 control bit29 during strobe", A_CTRL, 32'h2000_0000);
        @(negedge clk);
        #1;
        check("R8 strobe gone in second cycle", {31'b0, age_strobe}, 32'h0);
        check_reg("R8 control after strobe", A_CTRL, 32'h0);
    endtask

    task automatic t_clear;
        int n;
        bus_write(A_CTRL, 32'hC000_0000);
        check_reg("R7 control at clear start", A_CTRL, 32'hD000_0000);
        wait_idle(n);
        check("R7 busy cycle count", 32'(n), 32'(DEPTH));
        check_reg("R7 control after clear", A_CTRL, 32'h8000_0000);
        bus_write(A_TBL, 32'h0000_0007);
        check_words("R7 entry 7 freed", 32'h0, 32'h0, 32'h0);
        bus_write(A_TBL, 32'h0000_003F);
        check_words("R7 entry 63 freed", 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_busy_ignore;
        int n;
        bus_write(A_E0, 32'h0000_0005);
        bus_write(A_E1, 32'h2000_0003);
        bus_write(A_E2, 32'hCAFE_0003);
        bus_write(A_CTRL, 32'h4000_0000);
        repeat (10) @(negedge clk);
        bus_write(A_TBL, 32'h8000_0003);
        bus_write(A_TBL, 32'h0000_0005);
        check_reg("R9 still busy during ignored writes", A_CTRL, 32'h5000_0000);
        wait_idle(n);
        check_words("R9 load during clear ignored", 32'h5, 32'h2000_0003, 32'hCAFE_0003);
        check_reg("R9 index unchanged", A_TBL, 32'h0000_003F);
        bus_write(A_TBL, 32'h0000_0003);
        check_words("R9 commit during clear ignored", 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_precedence;
        int n;
        int hits;
        bus_write(A_CTRL, 32'h6000_0000);
        check("R10 no strobe with clear", {31'b0, age_strobe}, 32'h0);
        check_reg("R10 clear started", A_CTRL, 32'h5000_0000);
        bus_write(A_CTRL, 32'h2000_0000);
        hits = 0;
        n = 0;
        while (n < 2 * DEPTH) begin
            if (age_strobe) hits++;
            n++;
            @(negedge clk);
            #1;
        end
        check("R10 strobes during and after clear", 32'(hits), 32'h0);
        check_reg("R10 control idle afterwards", A_CTRL, 32'h0);
    endtask

    initial begin
        rst_n     = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_version();
        t_store();
        t_range();
        t_enable();
        t_age();
        t_clear();
        t_busy_ignore();
        t_precedence();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule